// File: doc/BRIEF.md
# TDM Multichannel Serial Framer

This block is the transmit and receive core of a time-division-multiplexed serial link. A single frame-sync pulse on `fs_in` opens a frame made of `NUM_SLOTS` back-to-back channel slots of `SLOT_W` bits each. After a programmable delay of 0 to 15 serial clock cycles, the block shifts receive bits in and transmit bits out, MSB first. It does this only in the slots selected by a static channel mask. No sync is needed per slot. Sync pulses that arrive while a frame is still claimed are dropped. Frames may follow one another with no gap, even when the next sync pulse lands inside the tail of the current frame.

Parallel words move through valid/ready handshakes. On the transmit side a one-word holding register sits in front of the shifter. On the receive side a one-word output register is used. The transmit strobe `tx_vld` is high for exactly the bit periods of enabled slots. It serves as the enable of the pad's tri-state driver, so `sd_out` is only meaningful while it is high. An empty holding register at the start of an enabled slot sends zeros and sets a sticky flag. A received word that overwrites an unread one also sets a sticky flag.

Everything runs from the serial clock `clk`. `fs_in` and `sd_in` are sampled on its rising edge. `sd_out` and `tx_vld` change on its falling edge. The reset is synchronous and active high. `NUM_SLOTS*SLOT_W` must be at least 16.

Top module: `tdm_framer`

## Requirements
- R1: After reset, `tx_vld`, `sd_out`, `rx_valid`, `tx_underflow` and `rx_overflow` are 0 and `tx_ready` is 1.
- R2: If `fs_in` is sampled high at rising edge t and the frame is accepted, bit 0 of slot 0 is sampled from `sd_in` at rising edge t+`cfg_delay`. With `cfg_delay`=0 this is the same edge as the sync. Bit b of the frame is sampled at edge t+`cfg_delay`+b.
- R3: The transmit bit for frame bit position b is launched on the falling edge that follows the rising edge where receive position b is sampled, and it is held for one clock. Words go out MSB first.
- R4: `tx_vld` is 1 for exactly the bit periods of slots whose `cfg_mask` bit is 1 (bit i selects slot i, slot 0 comes first after the sync). `sd_out` is 0 whenever `tx_vld` is 0.
- R5: A sync pulse sampled fewer than `NUM_SLOTS*SLOT_W` cycles after the last accepted one is ignored. This includes a pulse one cycle short of that distance.
- R6: A sync pulse sampled exactly `NUM_SLOTS*SLOT_W` cycles after the last accepted one is accepted, even during the last bits of the running frame. The next frame then follows with no gap and no lost bits, for any delay up to 15.
- R7: Each enabled receive slot yields one word on `rx_data`, with the first sampled bit as the MSB, and `rx_valid` set. The word is held stable until `rx_valid` and `rx_ready` are both high at a rising edge.
- R8: If a receive word completes while `rx_valid` is high and `rx_ready` is low, `rx_data` takes the new word and `rx_overflow` sets and stays set until reset.
- R9: `tx_ready` is 1 while the transmit holding register is empty. A word is taken when `tx_valid` and `tx_ready` are both high at a rising edge, after which `tx_ready` drops. The held word moves to the shifter at bit 0 of the next enabled slot.
- R10: If the holding register is empty at bit 0 of an enabled slot, that slot transmits all zeros with `tx_vld` still high, and `tx_underflow` sets and stays set until reset.
- R11: Disabled slots neither consume transmit words nor produce receive words, whatever `sd_in` carries during them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_delay | input | 4 | Cycles from frame sync to first data bit (0..15) |
| cfg_mask | input | NUM_SLOTS | Slot enable, bit i for slot i |
| fs_in | input | 1 | Frame sync pulse |
| sd_in | input | 1 | Serial receive data |
| sd_out | output | 1 | Serial transmit data (valid when tx_vld is 1) |
| tx_vld | output | 1 | Transmit-valid strobe and pad output enable |
| tx_data | input | SLOT_W | Transmit word |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Holding register can take a word |
| rx_data | output | SLOT_W | Last received word |
| rx_valid | output | 1 | Received word waiting |
| rx_ready | input | 1 | Consumer takes the received word |
| tx_underflow | output | 1 | Sticky: enabled slot found no word |
| rx_overflow | output | 1 | Sticky: unread received word overwritten |

## Verification
On every cycle the assertions check four things: the holding-register handshake, the stickiness of both error flags, that a held receive word stays stable under backpressure, and that `sd_out` stays low while the strobe is off. They also check that a new frame never begins while the previous one is still shifting, and that a sync inside the claimed window leaves the acceptance count running. Only the bench scenarios can show the exact cycle alignment of bits against the sync for delays 0, 3, 5 and 15. They also show that sync pulses mid-frame and one cycle early are rejected, that back-to-back frames with a long delay run without a seam, that masked slots are skipped, and that the bit order of each word is correct.

// File: rtl/tdm_pkg.sv
package tdm_pkg;

  // Per-cycle position report from the frame timer to the data lanes.
  typedef struct packed {
    logic act;    // a frame bit is being transferred this cycle
    logic first;  // bit 0 of a slot
    logic last;   // final bit of a slot
    logic en;     // the current slot is enabled by the mask
  } tdm_slot_t;

endpackage

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer
  import tdm_pkg::*;
#(
  parameter int SLOT_W    = 16,
  parameter int NUM_SLOTS = 8,
  parameter int DLY_W     = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 fs_in,
  input  logic [DLY_W-1:0]     cfg_delay,
  input  logic [NUM_SLOTS-1:0] cfg_mask,
  output tdm_slot_t            pos
);
  localparam int FB  = SLOT_W * NUM_SLOTS;
  localparam int BW  = $clog2(SLOT_W);
  localparam int SLW = $clog2(NUM_SLOTS);
  localparam int SNW = $clog2(FB + 1);
  localparam logic [SNW-1:0] FB_S     = SNW'(FB);
  localparam logic [BW-1:0]  LAST_BIT = BW'(SLOT_W - 1);
  localparam logic [SLW-1:0] LAST_SL  = SLW'(NUM_SLOTS - 1);

  logic [SNW-1:0]   since_q;   // cycles since the last accepted sync, saturating
  logic [DLY_W-1:0] cd_q;      // delay countdown, 1 marks the start cycle
  logic             run_q;
  logic [BW-1:0]    bit_q, bit_c;
  logic [SLW-1:0]   slot_q, slot_c;
  logic             acc, go, act;

  assign acc   = fs_in && (since_q == FB_S);
  assign go    = (acc && (cfg_delay == '0)) || (cd_q == DLY_W'(1));
  assign act   = go || run_q;
  assign bit_c = go ? '0 : bit_q;
  assign slot_c = go ? '0 : slot_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_q <= FB_S;
      cd_q    <= '0;
      run_q   <= 1'b0;
      bit_q   <= '0;
      slot_q  <= '0;
    end else begin
      if (acc)                 since_q <= SNW'(1);
      else if (since_q != FB_S) since_q <= since_q + 1'b1;

      if (acc && (cfg_delay != '0)) cd_q <= cfg_delay;
      else if (cd_q != '0)          cd_q <= cd_q - 1'b1;

      if (act) begin
        if (bit_c == LAST_BIT) begin
          bit_q <= '0;
          if (slot_c == LAST_SL) begin
            slot_q <= '0;
            run_q  <= 1'b0;
          end else begin
            slot_q <= slot_c + 1'b1;
            run_q  <= 1'b1;
          end
        end else begin
          bit_q  <= bit_c + 1'b1;
          slot_q <= slot_c;
          run_q  <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    pos.act   = act;
    pos.first = act && (bit_c == '0);
    pos.last  = act && (bit_c == LAST_BIT);
    pos.en    = act && cfg_mask[slot_c];
  end

  // R6: a new frame may only begin once the previous one has shifted out.
  a_r6_start_after_tail: assert property (@(posedge clk) disable iff (rst)
    go |-> !run_q);

  // R5: a sync inside the claimed window leaves the distance count running.
  a_r5_early_sync_ignored: assert property (@(posedge clk) disable iff (rst)
    (fs_in && since_q < FB_S) |=> since_q == $past(since_q) + 1'b1);

endmodule

// File: rtl/tdm_rx_lane.sv
module tdm_rx_lane
  import tdm_pkg::*;
#(
  parameter int SLOT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  tdm_slot_t         pos,
  input  logic              sd_in,
  output logic [SLOT_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic              rx_overflow
);
  logic [SLOT_W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q        <= '0;
      rx_data     <= '0;
      rx_valid    <= 1'b0;
      rx_overflow <= 1'b0;
    end else begin
      if (pos.en && pos.last) begin
        rx_data  <= {sh_q[SLOT_W-2:0], sd_in};
        rx_valid <= 1'b1;
        if (rx_valid && !rx_ready) rx_overflow <= 1'b1;
      end else begin
        if (pos.en) sh_q <= {sh_q[SLOT_W-2:0], sd_in};
        if (rx_valid && rx_ready) rx_valid <= 1'b0;
      end
    end
  end

  a_r7_valid_held: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rx_ready) |=> rx_valid);

  a_r7_data_stable: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rx_ready && !(pos.en && pos.last)) |=> $stable(rx_data));

  a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
    rx_overflow |=> rx_overflow);

endmodule

// File: rtl/tdm_tx_lane.sv
module tdm_tx_lane
  import tdm_pkg::*;
#(
  parameter int SLOT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  tdm_slot_t         pos,
  input  logic [SLOT_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              sd_out,
  output logic              tx_vld,
  output logic              tx_underflow
);
  logic [SLOT_W-1:0] hold_q, sh_q, word;
  logic              full_q, take, move, full_n;
  logic              bit_q, oe_q;

  assign take   = tx_valid && tx_ready;
  assign move   = pos.en && pos.first;
  assign full_n = (full_q && !move) || take;
  assign word   = full_q ? hold_q : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q       <= '0;
      full_q       <= 1'b0;
      tx_ready     <= 1'b1;
      sh_q         <= '0;
      bit_q        <= 1'b0;
      oe_q         <= 1'b0;
      tx_underflow <= 1'b0;
    end else begin
      if (take) hold_q <= tx_data;
      full_q   <= full_n;
      tx_ready <= !full_n;
      oe_q     <= pos.en;
      if (move) begin
        bit_q <= word[SLOT_W-1];
        sh_q  <= {word[SLOT_W-2:0], 1'b0};
        if (!full_q) tx_underflow <= 1'b1;
      end else if (pos.en) begin
        bit_q <= sh_q[SLOT_W-1];
        sh_q  <= {sh_q[SLOT_W-2:0], 1'b0};
      end else begin
        bit_q <= 1'b0;
      end
    end
  end

  // Launch stage on the opposite edge from the sampling edge.
  always_ff @(negedge clk) begin
    if (rst) begin
      sd_out <= 1'b0;
      tx_vld <= 1'b0;
    end else begin
      sd_out <= bit_q;
      tx_vld <= oe_q;
    end
  end

  a_r9_accept_blocks: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready) |=> !tx_ready);

  a_r10_underflow_sticky: assert property (@(posedge clk) disable iff (rst)
    tx_underflow |=> tx_underflow);

  a_r4_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
    !tx_vld |-> !sd_out);

endmodule

// File: rtl/tdm_framer.sv
module tdm_framer
  import tdm_pkg::*;
#(
  parameter int SLOT_W    = 16,
  parameter int NUM_SLOTS = 8,
  parameter int DLY_W     = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [DLY_W-1:0]     cfg_delay,
  input  logic [NUM_SLOTS-1:0] cfg_mask,
  input  logic                 fs_in,
  input  logic                 sd_in,
  output logic                 sd_out,
  output logic                 tx_vld,
  input  logic [SLOT_W-1:0]    tx_data,
  input  logic                 tx_valid,
  output logic                 tx_ready,
  output logic [SLOT_W-1:0]    rx_data,
  output logic                 rx_valid,
  input  logic                 rx_ready,
  output logic                 tx_underflow,
  output logic                 rx_overflow
);
  tdm_slot_t pos;

  tdm_frame_timer #(.SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS), .DLY_W(DLY_W)) u_timer (
    .clk(clk), .rst(rst), .fs_in(fs_in), .cfg_delay(cfg_delay),
    .cfg_mask(cfg_mask), .pos(pos)
  );

  tdm_tx_lane #(.SLOT_W(SLOT_W)) u_tx (
    .clk(clk), .rst(rst), .pos(pos), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .sd_out(sd_out), .tx_vld(tx_vld),
    .tx_underflow(tx_underflow)
  );

  tdm_rx_lane #(.SLOT_W(SLOT_W)) u_rx (
    .clk(clk), .rst(rst), .pos(pos), .sd_in(sd_in), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_overflow(rx_overflow)
  );

endmodule

// File: tb/tb_tdm_framer.sv
module tb_tdm_framer;
  localparam int SW = 8, NS = 4, FB = SW * NS, LEN = 160;

  logic clk = 1'b0, rst = 1'b1, fs_in = 1'b0, sd_in = 1'b0;
  logic tx_valid = 1'b0, rx_ready = 1'b0;
  logic [3:0] cfg_delay = '0;
  logic [NS-1:0] cfg_mask = '0;
  logic [SW-1:0] tx_data = '0;
  logic sd_out, tx_vld, tx_ready, rx_valid, tx_underflow, rx_overflow;
  logic [SW-1:0] rx_data;

  int total = 0, bad = 0;
  logic fs_plan[LEN], sdi_plan[LEN], oe_plan[LEN], sdo_plan[LEN];
  logic [SW-1:0] feed_q[$], txexp_q[$], rxexp_q[$];
  logic rxrdy = 1'b1;

  tdm_framer #(.SLOT_W(SW), .NUM_SLOTS(NS), .DLY_W(4)) dut (
    .clk(clk), .rst(rst), .cfg_delay(cfg_delay), .cfg_mask(cfg_mask),
    .fs_in(fs_in), .sd_in(sd_in), .sd_out(sd_out), .tx_vld(tx_vld),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .tx_underflow(tx_underflow), .rx_overflow(rx_overflow)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic clear_plan();
    for (int i = 0; i < LEN; i++) begin
      fs_plan[i] = 0; sdi_plan[i] = 0; oe_plan[i] = 0; sdo_plan[i] = 0;
    end
  endtask

  // Driver side of the scoreboard: schedules line activity and queues expectations.
  task automatic add_frame(input int k0, input int d, input logic [FB-1:0] rxw,
                           input logic [FB-1:0] txw, input bit feed, input bit want_rx);
    fs_plan[k0] = 1;
    for (int s = 0; s < NS; s++) begin
      if (cfg_mask[s]) begin
        if (want_rx) rxexp_q.push_back(rxw[FB-1-s*SW -: SW]);
        if (feed) begin
          feed_q.push_back(txw[FB-1-s*SW -: SW]);
          txexp_q.push_back(txw[FB-1-s*SW -: SW]);
        end else begin
          txexp_q.push_back('0);
        end
      end
    end
    for (int b = 0; b < FB; b++) begin
      if (cfg_mask[b / SW]) begin
        sdi_plan[k0+d+b] = rxw[FB-1-b];
        oe_plan[k0+d+b]  = 1;
        sdo_plan[k0+d+b] = feed ? txw[FB-1-b] : 1'b0;
      end else begin
        sdi_plan[k0+d+b] = 1'b1;
      end
    end
  endtask

  // Playback plus monitor: drives the plan and compares outputs as they appear.
  task automatic play(input int n, input int rdy_k, input string tag);
    logic [SW-1:0] mon = '0;
    logic [SW-1:0] e;
    int mcnt = 0;
    int miss = 0;
    for (int k = 0; k <= n; k++) begin
      tick();
      if (k > 0) begin
        if (tx_vld !== oe_plan[k-1] || sd_out !== sdo_plan[k-1]) miss++;
        if (tx_vld) begin
          mon = {mon[SW-2:0], sd_out};
          mcnt++;
          if (mcnt == SW) begin
            mcnt = 0;
            if (txexp_q.size() == 0) check(0, "R3 unexpected tx word", mon, 0);
            else begin
              e = txexp_q.pop_front();
              check(mon == e, "R3 tx word MSB first", mon, e);
            end
          end
        end
      end
      if (k == rdy_k) check(tx_ready == 1'b0, "R9 full holder drops ready", tx_ready, 0);
      fs_in = (k < n) ? fs_plan[k] : 1'b0;
      sd_in = (k < n) ? sdi_plan[k] : 1'b0;
      rx_ready = rxrdy;
      if (rx_valid && rxrdy) begin
        if (rxexp_q.size() == 0) check(0, "R11 unexpected rx word", rx_data, 0);
        else begin
          e = rxexp_q.pop_front();
          check(rx_data == e, "R7 rx word", rx_data, e);
        end
      end
      if (tx_ready && feed_q.size() > 0) begin
        tx_valid = 1'b1;
        tx_data  = feed_q.pop_front();
      end else begin
        tx_valid = 1'b0;
      end
    end
    check(miss == 0, tag, miss, 0);
    check(txexp_q.size() == 0, "R9 every queued tx word sent", txexp_q.size(), 0);
    if (rxrdy) check(rxexp_q.size() == 0, "R11 every enabled rx slot seen", rxexp_q.size(), 0);
  endtask

  initial begin
    #4_000_000;
    total++;
    bad++;
    $display("FAIL watchdog expired act=1 exp=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    clear_plan();
    rst = 1'b1;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R1 reset state
    check(tx_vld == 0, "R1 strobe low", tx_vld, 0);
    check(sd_out == 0, "R1 data low", sd_out, 0);
    check(rx_valid == 0, "R1 no rx word", rx_valid, 0);
    check(tx_ready == 1, "R1 holder ready", tx_ready, 1);
    check(tx_underflow == 0 && rx_overflow == 0, "R1 flags clear",
          {tx_underflow, rx_overflow}, 0);

    // R2 zero delay, all slots, R5 sync in mid-frame dropped
    cfg_delay = 4'd0; cfg_mask = 4'b1111;
    clear_plan();
    add_frame(4, 0, 32'hA5C3_0FF1, 32'h3C81_7ED2, 1, 1);
    fs_plan[14] = 1;
    play(50, 3, "R2 R5 zero-delay frame with mid-frame sync");

    // R11 sparse mask, R5 sync one cycle short of a frame
    cfg_delay = 4'd3; cfg_mask = 4'b1010;
    clear_plan();
    add_frame(4, 3, 32'h1234_5678, 32'h9ABC_DEF0, 1, 1);
    fs_plan[4+FB-1] = 1;
    play(60, -1, "R11 R5 masked slots and boundary sync");

    // R6 back-to-back frames at maximum delay
    cfg_delay = 4'd15; cfg_mask = 4'b1001;
    clear_plan();
    add_frame(2, 15, 32'hC001_D00D, 32'h8E11_0A7F, 1, 1);
    add_frame(2+FB, 15, 32'h5A00_00A5, 32'h6600_0099, 1, 1);
    add_frame(2+2*FB, 15, 32'hF000_000F, 32'h1100_00EE, 1, 1);
    play(2+2*FB+15+FB+3, -1, "R6 R2 seamless frames at delay 15");

    // R8 overflow with consumer stalled, R10 underflow with no words
    cfg_delay = 4'd5; cfg_mask = 4'b1111;
    rxrdy = 1'b0;
    clear_plan();
    add_frame(2, 5, 32'h0102_0304, 32'hFFFF_FFFF, 0, 0);
    play(45, -1, "R10 empty slots strobed with zeros");
    check(rx_overflow == 1, "R8 overflow flag", rx_overflow, 1);
    check(rx_data == 8'h04, "R8 newest word kept", rx_data, 8'h04);
    check(rx_valid == 1, "R7 word held under backpressure", rx_valid, 1);
    check(tx_underflow == 1, "R10 underflow flag", tx_underflow, 1);
    rxrdy = 1'b1; rx_ready = 1'b1;
    tick();
    tick();
    check(rx_valid == 0, "R7 word released by ready", rx_valid, 0);
    check(rx_overflow == 1, "R8 flag sticky", rx_overflow, 1);

    rst = 1'b1;
    repeat (2) tick();
    rst = 1'b0;
    tick();
    check(tx_underflow == 0 && rx_overflow == 0, "R1 flags cleared by reset",
          {tx_underflow, rx_overflow}, 0);
    check(tx_ready == 1, "R1 ready after reset", tx_ready, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule